// File: doc/BRIEF.md
# Prioritised 32-Line Interrupt Controller

The block gathers 32 active-low interrupt lines and presents two requests to a processor: a normal request (`irq_o`) and a fast request (`fiq_o`). Each line has its own configuration word. The word sets a 5-bit priority, chooses falling-edge or low-level sensing, and routes the line to one of the two requests. A pending bit records each line's request. A mask bit holds back each line. For each request, a search picks the unmasked pending line with the best priority among the lines routed to that request. That line's number is latched as a source code.

Each request output has an arming flag. When the flag is armed and a qualifying line exists, the output rises and the code is latched. The flag then clears. The output stays high and the code stays frozen until software writes the control register to re-arm the flag. Software reads the code to find the source. That read also clears the pending bit when the source line is edge-sensed.

The register interface has 32-bit words and single-cycle access. `bus_rdata` is valid in the same cycle as the read request. Any side effect of the access takes place at the next rising clock edge. The line inputs are taken as synchronous to `clk`.

Top module: `lineprio_intc`

## Requirements
- R1: After reset, the mask word (offset 0x04) reads 0xFFFFFFFF. The pending word (0x00) and every configuration word read 0. Both request outputs are low. Both source codes read 0.
- R2: The configuration word for line n sits at offset 0x1C + 4*n. Bits [6:2] hold the priority, bit 1 selects low-level sensing when 1 (falling edge when 0), and bit 0 routes the line to `fiq_o` when 1. All other bits read back as 0.
- R3: For an edge-sensed line, the pending bit (bit n of offset 0x00) is set only in the cycle after the line changes from high to low. Holding the line low does not set the bit again. Releasing the line does not clear the bit.
- R4: For a level-sensed line, the pending bit is 1 in the cycle after any cycle in which the line is low. The bit clears at the edge where the line goes back high.
- R5: A write to offset 0x00 ANDs the pending word with the written data. An exception applies to a level-sensed line whose input is still low: that line stays pending.
- R6: A line drives a request only when its mask bit (bit n of offset 0x04) is 0. It drives only the request chosen by its route bit. A write to the mask word takes part in the evaluation at the next edge.
- R7: When a request's flag is armed and a qualifying line exists at a clock edge, the output is high after that edge and the code is latched. The flag then clears. The output and the code then hold until a re-arm, even if a better line arrives later.
- R8: The winner is the line with the numerically lowest priority value. Among lines with equal priority, the highest line number wins.
- R9: A read of offset 0x10 returns the code latched for `irq_o`, and a read of offset 0x14 returns the code for `fiq_o`. If the coded line is edge-sensed, the read clears its pending bit. A level-sensed line stays pending.
- R10: A write to offset 0x18 with bit 0 set re-arms `irq_o`, and bit 1 does the same for `fiq_o`. The output drops unless a qualifying line exists. If one exists, the output stays high and the new winner's code is latched at the same edge. Offset 0x18 reads 0.
- R11: A write to offset 0x9C acts only on the lowest set bit of the data. That line is treated as newly activated and becomes pending. Offset 0x9C reads 0.
- R12: A read of an undefined offset returns 0. A write to one changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_n | input | N_LINES | Interrupt lines, active low |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the request cycle |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The hardest state to reach is a request that has fired and is frozen while a better line arrives. The code must not move until the re-arm. After the re-arm, the output must stay high while the code jumps to the new winner at the same edge. The stimulus first raises a low-priority line and lets the output fire. It then raises a better line, reads the code, and writes the control word. The output is checked at the edge after that write, and the code is read back again. Priority ties and the clear-on-read rule are walked through a table of line pairs. In that table the winner's pending bit must vanish while the loser's bit remains.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int unsigned OFS_PEND     = 'h00;
    localparam int unsigned OFS_MASK     = 'h04;
    localparam int unsigned OFS_CODE_IRQ = 'h10;
    localparam int unsigned OFS_CODE_FIQ = 'h14;
    localparam int unsigned OFS_CTRL     = 'h18;
    localparam int unsigned OFS_CFG_BASE = 'h1C;
    localparam int unsigned OFS_SWSET    = 'h9C;

    localparam int unsigned CLS_IRQ = 0;
    localparam int unsigned CLS_FIQ = 1;
    localparam int unsigned N_CLS   = 2;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PEND,
        SEL_MASK,
        SEL_CODE_IRQ,
        SEL_CODE_FIQ,
        SEL_CTRL,
        SEL_CFG,
        SEL_SWSET
    } reg_sel_e;

endpackage

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
    parameter int unsigned N_LINES = 32,
    parameter int unsigned PRIO_W  = 5,
    localparam int unsigned ID_W   = $clog2(N_LINES)
) (
    input  logic [N_LINES-1:0]             cand,
    input  logic [N_LINES-1:0][PRIO_W-1:0] prio,
    output logic                           any,
    output logic [ID_W-1:0]                win
);

    logic [PRIO_W-1:0] best;

    // lowest value wins; "<=" lets a later (higher) line take a tie
    always_comb begin
        best = '1;
        win  = '0;
        for (int i = 0; i < int'(N_LINES); i++) begin
            if (cand[i] && (prio[i] <= best)) begin
                best = prio[i];
                win  = ID_W'(i);
            end
        end
        any = |cand;
    end

endmodule

// File: rtl/intc_pend_ctl.sv
module intc_pend_ctl #(
    parameter int unsigned N_LINES = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] act,
    input  logic [N_LINES-1:0] act_prev,
    input  logic [N_LINES-1:0] lvl,
    input  logic [N_LINES-1:0] pend_q,
    input  logic [N_LINES-1:0] keep,
    input  logic [N_LINES-1:0] rd_clr,
    input  logic [N_LINES-1:0] sw_set,
    output logic [N_LINES-1:0] pend_d
);

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        always_comb begin
            if (lvl[i]) begin
                // level: held while low, dropped on release, kept otherwise
                pend_d[i] = act[i] | sw_set[i] | (pend_q[i] & keep[i] & ~act_prev[i]);
            end else begin
                // edge: set on new activation, cleared by write or code read
                pend_d[i] = (pend_q[i] & keep[i] & ~rd_clr[i])
                          | (act[i] & ~act_prev[i])
                          | (sw_set[i] & ~act[i]);
            end
        end

        a_r4_level_held: assert property (@(posedge clk) disable iff (!rst_n)
            (lvl[i] && act[i]) |=> pend_q[i]);

        a_r4_level_release: assert property (@(posedge clk) disable iff (!rst_n)
            (lvl[i] && act_prev[i] && !act[i] && !sw_set[i]) |=> !pend_q[i]);
    end

endmodule

// File: rtl/lineprio_intc.sv
module lineprio_intc #(
    parameter int unsigned N_LINES = 32,
    parameter int unsigned PRIO_W  = 5,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] line_n,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_o,
    output logic               fiq_o
);
    import intc_pkg::*;

    localparam int unsigned ID_W     = $clog2(N_LINES);
    localparam int unsigned CFG_LAST = OFS_CFG_BASE + 4 * (N_LINES - 1);

    typedef struct packed {
        logic [N_LINES-1:0]             pend;
        logic [N_LINES-1:0]             mask;
        logic [N_LINES-1:0]             lvl;
        logic [N_LINES-1:0]             to_fiq;
        logic [N_LINES-1:0]             act_prev;
        logic [N_LINES-1:0][PRIO_W-1:0] prio;
        logic [N_CLS-1:0]               armed;
        logic [N_CLS-1:0]               out;
        logic [N_CLS-1:0][ID_W-1:0]     code;
    } state_t;

    state_t state_d, state_q;

    logic [N_LINES-1:0] act;
    reg_sel_e           sel;
    logic [ID_W-1:0]    cfg_idx;
    logic               wr, rd;
    logic [N_LINES-1:0] keep, rd_clr, sw_set, pend_nxt;
    logic [DATA_W-1:0]  low_bit;
    logic [N_CLS-1:0][N_LINES-1:0] cand;
    logic [N_CLS-1:0]              any_w;
    logic [N_CLS-1:0][ID_W-1:0]    win_w;
    logic [N_CLS-1:0]              rearm;

    assign act = ~line_n;
    assign wr  = bus_req & bus_we;
    assign rd  = bus_req & ~bus_we;

    // address decode
    always_comb begin
        sel     = SEL_NONE;
        cfg_idx = ID_W'((bus_addr - ADDR_W'(OFS_CFG_BASE)) >> 2);
        if      (bus_addr == ADDR_W'(OFS_PEND))     sel = SEL_PEND;
        else if (bus_addr == ADDR_W'(OFS_MASK))     sel = SEL_MASK;
        else if (bus_addr == ADDR_W'(OFS_CODE_IRQ)) sel = SEL_CODE_IRQ;
        else if (bus_addr == ADDR_W'(OFS_CODE_FIQ)) sel = SEL_CODE_FIQ;
        else if (bus_addr == ADDR_W'(OFS_CTRL))     sel = SEL_CTRL;
        else if (bus_addr == ADDR_W'(OFS_SWSET))    sel = SEL_SWSET;
        else if (bus_addr >= ADDR_W'(OFS_CFG_BASE) && bus_addr <= ADDR_W'(CFG_LAST)
                 && bus_addr[1:0] == 2'b00)          sel = SEL_CFG;
    end

    // candidate sets and priority search per request class
    for (genvar c = 0; c < N_CLS; c++) begin : g_cls
        assign cand[c]  = state_q.pend & ~state_q.mask
                        & ((c == CLS_FIQ) ? state_q.to_fiq : ~state_q.to_fiq);
        assign rearm[c] = wr && (sel == SEL_CTRL) && bus_wdata[c];

        intc_prio_pick #(.N_LINES(N_LINES), .PRIO_W(PRIO_W)) i_pick (
            .cand (cand[c]),
            .prio (state_q.prio),
            .any  (any_w[c]),
            .win  (win_w[c])
        );
    end

    // pending-bit modifiers
    assign low_bit = bus_wdata & (~bus_wdata + 1'b1);

    always_comb begin
        keep   = (wr && sel == SEL_PEND) ? bus_wdata[N_LINES-1:0] : '1;
        sw_set = (wr && sel == SEL_SWSET) ? low_bit[N_LINES-1:0] : '0;
        rd_clr = '0;
        if (rd && sel == SEL_CODE_IRQ)
            rd_clr[state_q.code[CLS_IRQ]] = ~state_q.lvl[state_q.code[CLS_IRQ]];
        if (rd && sel == SEL_CODE_FIQ)
            rd_clr[state_q.code[CLS_FIQ]] = ~state_q.lvl[state_q.code[CLS_FIQ]];
    end

    intc_pend_ctl #(.N_LINES(N_LINES)) i_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .act_prev (state_q.act_prev),
        .lvl      (state_q.lvl),
        .pend_q   (state_q.pend),
        .keep     (keep),
        .rd_clr   (rd_clr),
        .sw_set   (sw_set),
        .pend_d   (pend_nxt)
    );

    // next-state
    always_comb begin
        state_d          = state_q;
        state_d.act_prev = act;
        state_d.pend     = pend_nxt;

        if (wr && sel == SEL_MASK)
            state_d.mask = bus_wdata[N_LINES-1:0];

        if (wr && sel == SEL_CFG) begin
            state_d.prio[cfg_idx]   = bus_wdata[PRIO_W+1:2];
            state_d.lvl[cfg_idx]    = bus_wdata[1];
            state_d.to_fiq[cfg_idx] = bus_wdata[0];
        end

        for (int c = 0; c < int'(N_CLS); c++) begin
            if ((state_q.armed[c] || rearm[c]) && any_w[c]) begin
                state_d.armed[c] = 1'b0;
                state_d.out[c]   = 1'b1;
                state_d.code[c]  = win_w[c];
            end else begin
                state_d.armed[c] = state_q.armed[c] | rearm[c];
                state_d.out[c]   = state_q.out[c] & ~rearm[c];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q          <= '0;
            state_q.mask     <= '1;
            state_q.armed    <= '1;
        end else begin
            state_q <= state_d;
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_PEND:     bus_rdata[N_LINES-1:0] = state_q.pend;
            SEL_MASK:     bus_rdata[N_LINES-1:0] = state_q.mask;
            SEL_CODE_IRQ: bus_rdata[ID_W-1:0]    = state_q.code[CLS_IRQ];
            SEL_CODE_FIQ: bus_rdata[ID_W-1:0]    = state_q.code[CLS_FIQ];
            SEL_CFG: begin
                bus_rdata[PRIO_W+1:2] = state_q.prio[cfg_idx];
                bus_rdata[1]          = state_q.lvl[cfg_idx];
                bus_rdata[0]          = state_q.to_fiq[cfg_idx];
            end
            default:      bus_rdata = '0;
        endcase
    end

    assign irq_o = state_q.out[CLS_IRQ];
    assign fiq_o = state_q.out[CLS_FIQ];

    a_r7_fire_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.armed[CLS_IRQ] && any_w[CLS_IRQ]) |=> irq_o);

    a_r7_hold_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !rearm[CLS_IRQ]) |=> (irq_o && $stable(state_q.code[CLS_IRQ])));

    a_r7_hold_fiq: assert property (@(posedge clk) disable iff (!rst_n)
        (fiq_o && !rearm[CLS_FIQ]) |=> (fiq_o && $stable(state_q.code[CLS_FIQ])));

    a_r6_rose_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(any_w[CLS_IRQ]));

    a_r10_drop_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (rearm[CLS_IRQ] && !any_w[CLS_IRQ]) |=> !irq_o);

    a_r11_single_line: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sw_set));

endmodule

// File: tb/test_lineprio_intc.sv
module test_lineprio_intc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] line_n = '1;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    lineprio_intc i_lineprio_intc (
        .clk(clk), .rst_n(rst_n), .line_n(line_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    // {line_a, prio_a, line_b, prio_b, expected winner}
    localparam logic [24:0] VEC [0:5] = '{
        {5'd3,  5'd5,  5'd10, 5'd2,  5'd10},
        {5'd3,  5'd2,  5'd10, 5'd5,  5'd3},
        {5'd7,  5'd4,  5'd20, 5'd4,  5'd20},
        {5'd31, 5'd0,  5'd0,  5'd0,  5'd31},
        {5'd0,  5'd1,  5'd31, 5'd9,  5'd0},
        {5'd15, 5'd31, 5'd16, 5'd31, 5'd16}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    function automatic logic [7:0] cfg_ofs(input int line);
        return 8'(8'h1C + 4 * line);
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        rd(8'h04, v); chk("R1 mask", v, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R1 pend", v, 32'h0);
        rd(cfg_ofs(17), v); chk("R1 cfg", v, 32'h0);
        chk("R1 outs", {30'h0, fiq_o, irq_o}, 32'h0);
        rd(8'h14, v); chk("R1 fiq code", v, 32'h0);

        // R12 undefined offset
        wr(8'h08, 32'hDEAD_BEEF);
        rd(8'h08, v); chk("R12 undefined read", v, 32'h0);
        rd(8'h04, v); chk("R12 mask untouched", v, 32'hFFFF_FFFF);

        // R2 config layout
        wr(cfg_ofs(9), 32'hFFFF_FFFF);
        rd(cfg_ofs(9), v); chk("R2 cfg readback", v, 32'h7F);
        wr(cfg_ofs(9), 32'h0);

        // R3 edge sensing (all masked)
        line_n[4] = 1'b0; cyc(1);
        rd(8'h00, v); chk("R3 edge set", v, 32'h10);
        wr(8'h00, 32'h0);
        rd(8'h00, v); chk("R3 no reset while held", v, 32'h0);
        line_n[4] = 1'b1; cyc(1);
        line_n[4] = 1'b0; cyc(1);
        line_n[4] = 1'b1; cyc(1);
        rd(8'h00, v); chk("R3 release keeps", v, 32'h10);
        wr(8'h00, 32'h0);

        // R4 / R5 level sensing
        wr(cfg_ofs(6), 32'h2);
        line_n[6] = 1'b0; cyc(1);
        rd(8'h00, v); chk("R4 level set", v, 32'h40);
        wr(8'h00, 32'h0);
        rd(8'h00, v); chk("R5 active level kept", v, 32'h40);
        line_n[6] = 1'b1; cyc(1);
        rd(8'h00, v); chk("R4 level released", v, 32'h0);
        line_n[2:1] = 2'b00; cyc(1);
        line_n[2:1] = 2'b11; cyc(1);
        wr(8'h00, ~32'h2);
        rd(8'h00, v); chk("R5 and-write", v, 32'h4);
        wr(8'h00, 32'h0);

        // R11 software set
        wr(8'h9C, 32'h3000);
        rd(8'h00, v); chk("R11 lowest bit only", v, 32'h1000);
        rd(8'h9C, v); chk("R11 reads zero", v, 32'h0);
        wr(8'h00, 32'h0);

        // R8 / R9 priority table
        wr(8'h04, 32'h0);
        for (int n = 0; n < 6; n++) begin
            int la, lb, ex;
            la = int'(VEC[n][24:20]); lb = int'(VEC[n][14:10]); ex = int'(VEC[n][4:0]);
            wr(cfg_ofs(la), {25'h0, VEC[n][19:15], 2'b00});
            wr(cfg_ofs(lb), {25'h0, VEC[n][9:5], 2'b00});
            line_n[la] = 1'b0; line_n[lb] = 1'b0;
            cyc(2);
            chk("R7 irq fired", {31'h0, irq_o}, 32'h1);
            rd(8'h10, v); chk("R8 winner", v, 32'(ex));
            rd(8'h00, v);
            chk("R9 edge clear-on-read", v, 32'h1 << ((ex == la) ? lb : la));
            line_n[la] = 1'b1; line_n[lb] = 1'b1; cyc(1);
            wr(8'h00, 32'h0);
            wr(8'h18, 32'h1);
        end

        // R9 level winner not cleared
        wr(cfg_ofs(6), 32'h2);
        line_n[6] = 1'b0; cyc(2);
        rd(8'h10, v); chk("R9 level code", v, 32'd6);
        rd(8'h00, v); chk("R9 level stays", v, 32'h40);
        line_n[6] = 1'b1; cyc(1);
        wr(8'h00, 32'h0);
        wr(8'h18, 32'h1);

        // R7 / R10 freeze and re-arm
        wr(cfg_ofs(8), 32'(10 << 2));
        wr(cfg_ofs(9), 32'(1 << 2));
        line_n[8] = 1'b0; cyc(2);
        chk("R7 fired", {31'h0, irq_o}, 32'h1);
        line_n[9] = 1'b0; cyc(2);
        rd(8'h10, v); chk("R7 code frozen", v, 32'd8);
        wr(8'h18, 32'h1);
        chk("R10 stays high", {31'h0, irq_o}, 32'h1);
        rd(8'h10, v); chk("R10 new code", v, 32'd9);
        rd(8'h18, v); chk("R10 ctrl reads 0", v, 32'h0);
        line_n[9:8] = 2'b11; cyc(1);
        wr(8'h00, 32'h0);
        wr(8'h18, 32'h1);
        chk("R10 drops", {31'h0, irq_o}, 32'h0);

        // R6 masking
        wr(8'h04, 32'hFFFF_FFFF);
        line_n[11] = 1'b0; cyc(2);
        chk("R6 masked quiet", {31'h0, irq_o}, 32'h0);
        wr(8'h04, ~(32'h1 << 11));
        cyc(1);
        chk("R6 unmask fires", {31'h0, irq_o}, 32'h1);
        line_n[11] = 1'b1; cyc(1);
        wr(8'h00, 32'h0);
        wr(8'h18, 32'h1);
        wr(8'h04, 32'h0);

        // R6 / R9 fast route
        wr(cfg_ofs(5), 32'h1);
        line_n[5] = 1'b0; cyc(2);
        chk("R6 fiq route", {30'h0, fiq_o, irq_o}, 32'h2);
        rd(8'h14, v); chk("R9 fiq code", v, 32'd5);
        rd(8'h00, v); chk("R9 fiq read clears", v, 32'h0);
        line_n[5] = 1'b1; cyc(1);
        wr(8'h18, 32'h2);
        chk("R10 fiq drops", {31'h0, fiq_o}, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule